// File: doc/BRIEF.md
# Flash Command Sequencer and Status Register

This block sits behind the host-side write path of a NOR-style flash controller. Each host write carries an address and a command byte. The block reads these bytes as commands and tracks several things: the selected read source (array data or the status byte), a ready/busy operation state, and pending suspends. It sends start, suspend and resume pulses to an abstracted program/erase timer, which reports back with a one-cycle completion pulse. The array algorithms themselves, buffer storage and identification data are outside this block.

Some commands take more than one write. A word program takes a setup byte and then a data write. A block erase takes a setup byte and then a confirm to the same block. A buffered program takes a setup byte, a word count, the load writes and then a confirm. When a confirm slot holds the wrong byte or the wrong block, the block raises sequence-error flags and does not start the operation. A running program or erase can be suspended and later resumed. While an erase is suspended, programs to other blocks may run.

The status byte uses these bits:
- bit 7: ready
- bit 6: erase suspended
- bit 5: erase or sequence error
- bit 4: program or sequence error
- bit 2: program suspended

All other bits read 0.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After synchronous reset, `rd_sel` is 0 (array read), `status` is 0x80, and no pulse output is high.
- R2: While ready, 0x70 sets `rd_sel` to 1 and 0xFF sets it to 0. In the idle ready state, every byte other than 0x40, 0xE8, 0x20, 0x70 and 0x50 leaves `rd_sel`, `status` and all pulses unchanged.
- R3: Writing 0x40 and then any data write raises `op_start` for exactly one cycle after the data write. At the same time `op_kind` is 1 and `op_block` is the data address's upper BLK_W bits. Status bit 7 reads 0 until the cycle after `op_done`.
- R4: While status bit 7 is 0, `rd_sel` reads 1 whatever read source was selected. Once the operation completes, the selected source applies again.
- R5: Writing 0x20 and then 0xD0 to the same block raises `op_start` with `op_kind` 3 and that block.
- R6: After 0x20, a confirm slot that holds a byte other than 0xD0, or that targets another block, starts nothing and sets status to 0xB0.
- R7: The 0xE8 setup is followed by a count n, then n+1 load writes, then 0xD0 to the setup block. This starts `op_kind` 2 on the setup block. A count of BUF_WORDS or more is a sequence error (0xB0).
- R8: In the buffered confirm slot, any byte other than 0xD0, or a 0xD0 aimed at a different block, starts nothing and sets bits 7, 5 and 4 (0xB0).
- R9: 0x50 clears bits 5 and 4.
- R10: While bit 5 or bit 4 is set, 0x40, 0xE8 and 0x20 are ignored.
- R11: 0xB0 to any address while busy gives one `op_suspend` pulse and sets bit 7. It also sets bit 6 for an erase or bit 2 for a program. When the block is not busy, 0xB0 is ignored.
- R12: 0xD0 while suspended gives one `op_resume` pulse with the suspended operation's kind and block. It clears the suspend bit and bit 7.
- R13: During an erase suspend, a program to another block starts normally, and its completion returns status to 0xC0. A program aimed at the suspended block starts nothing and sets bit 4. A 0xB0 during that nested program is ignored.
- R14: Bits 5 and 4 stay set through every other command until 0x50.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Host write strobe, one cycle per write |
| wr_addr | input | ADDR_W | Write address; upper BLK_W bits select the block |
| wr_data | input | 8 | Command or data byte |
| op_done | input | 1 | Completion pulse from the program/erase timer |
| rd_sel | output | 1 | Read source: 0 array, 1 status |
| status | output | 8 | Status byte |
| op_start | output | 1 | One-cycle start pulse |
| op_suspend | output | 1 | One-cycle suspend pulse |
| op_resume | output | 1 | One-cycle resume pulse |
| op_kind | output | 2 | Kind of the started or resumed operation: 1 word, 2 buffer, 3 erase |
| op_block | output | BLK_W | Block of the started or resumed operation |

## Verification
The hardest situation to reach is a program nested inside an erase suspend. The stimulus has to start an erase and suspend it while busy. It then runs a word program to another block and tries a suspend during that program, which must be refused. The timer then completes, and the flags must return to the erase-suspended pattern. After that, the stimulus aims word and buffered programs at the suspended block and checks that they are refused with bit 4. It then writes a 0xD0 after an erase setup that the block ignored; this 0xD0 must resume the original erase. The word, erase and buffered sequences are swept over every block and every legal count, and every byte is swept through the idle decoder.

// File: rtl/flc_pkg.sv
package flc_pkg;
  localparam logic [7:0] C_RD_ARRAY  = 8'hFF;
  localparam logic [7:0] C_WORD_PGM  = 8'h40;
  localparam logic [7:0] C_BUF_PGM   = 8'hE8;
  localparam logic [7:0] C_ERASE     = 8'h20;
  localparam logic [7:0] C_CONFIRM   = 8'hD0;
  localparam logic [7:0] C_SUSPEND   = 8'hB0;
  localparam logic [7:0] C_RD_STATUS = 8'h70;
  localparam logic [7:0] C_CLR_ERR   = 8'h50;

  localparam logic [1:0] K_NONE  = 2'd0;
  localparam logic [1:0] K_WORD  = 2'd1;
  localparam logic [1:0] K_BUF   = 2'd2;
  localparam logic [1:0] K_ERASE = 2'd3;

  typedef struct packed {
    logic rd_array;
    logic word;
    logic buf_pgm;
    logic erase;
    logic confirm;
    logic suspend;
    logic rd_status;
    logic clear;
  } cmd_t;

  typedef enum logic [2:0] {
    S_IDLE, S_WP_DATA, S_BP_COUNT, S_BP_LOAD, S_BP_CONF, S_ER_CONF, S_BUSY
  } seq_state_t;
endpackage

// File: rtl/flc_decode.sv
module flc_decode
  import flc_pkg::*;
(
  input  logic [7:0] code,
  output cmd_t       cmd
);
  always_comb begin
    cmd           = '0;
    cmd.rd_array  = (code == C_RD_ARRAY);
    cmd.word      = (code == C_WORD_PGM);
    cmd.buf_pgm   = (code == C_BUF_PGM);
    cmd.erase     = (code == C_ERASE);
    cmd.confirm   = (code == C_CONFIRM);
    cmd.suspend   = (code == C_SUSPEND);
    cmd.rd_status = (code == C_RD_STATUS);
    cmd.clear     = (code == C_CLR_ERR);
  end
endmodule

// File: rtl/flc_errs.sv
module flc_errs (
  input  logic clk,
  input  logic rst,
  input  logic set_seq,
  input  logic set_pgm,
  input  logic clr,
  output logic err_erase,
  output logic err_pgm
);
  always_ff @(posedge clk) begin
    if (rst) begin
      err_erase <= 1'b0;
      err_pgm   <= 1'b0;
    end else if (clr) begin
      err_erase <= 1'b0;
      err_pgm   <= 1'b0;
    end else begin
      if (set_seq) begin
        err_erase <= 1'b1;
        err_pgm   <= 1'b1;
      end
      if (set_pgm) err_pgm <= 1'b1;
    end
  end
endmodule

// File: rtl/flc_seq.sv
module flc_seq
  import flc_pkg::*;
#(
  parameter int BLK_W     = 4,
  parameter int BUF_WORDS = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [7:0]       wr_data,
  input  logic [BLK_W-1:0] wr_blk,
  input  cmd_t             cmd,
  input  logic             op_done,
  input  logic             err_any,
  output logic             ready,
  output logic             esusp,
  output logic             psusp,
  output logic             mode_status,
  output logic             op_start,
  output logic             op_suspend,
  output logic             op_resume,
  output logic [1:0]       op_kind,
  output logic [BLK_W-1:0] op_block,
  output logic             set_seq,
  output logic             set_pgm,
  output logic             do_clear
);
  localparam int CNT_W = (BUF_WORDS > 1) ? $clog2(BUF_WORDS) : 1;

  seq_state_t       state;
  logic [1:0]       act_kind;
  logic [BLK_W-1:0] act_blk, er_blk, pend_blk;
  logic [CNT_W-1:0] cnt;

  logic             launch;
  logic [1:0]       l_kind;
  logic [BLK_W-1:0] l_blk;

  always_comb begin
    launch  = 1'b0;
    l_kind  = K_WORD;
    l_blk   = wr_blk;
    set_seq = 1'b0;
    set_pgm = 1'b0;
    if (wr_en) begin
      case (state)
        S_WP_DATA: launch = 1'b1;
        S_BP_COUNT: if (int'(wr_data) >= BUF_WORDS) set_seq = 1'b1;
        S_BP_CONF: begin
          if (cmd.confirm && wr_blk == pend_blk) begin
            launch = 1'b1;
            l_kind = K_BUF;
            l_blk  = pend_blk;
          end else set_seq = 1'b1;
        end
        S_ER_CONF: begin
          if (cmd.confirm && wr_blk == pend_blk) begin
            launch = 1'b1;
            l_kind = K_ERASE;
            l_blk  = pend_blk;
          end else set_seq = 1'b1;
        end
        default: ;
      endcase
    end
    if (launch && esusp && l_blk == er_blk) begin
      launch  = 1'b0;
      set_pgm = 1'b1;
    end
  end

  assign do_clear = wr_en && cmd.clear && (state == S_IDLE || state == S_BUSY);

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= S_IDLE;
      ready       <= 1'b1;
      esusp       <= 1'b0;
      psusp       <= 1'b0;
      mode_status <= 1'b0;
      op_start    <= 1'b0;
      op_suspend  <= 1'b0;
      op_resume   <= 1'b0;
      op_kind     <= K_NONE;
      op_block    <= '0;
      act_kind    <= K_NONE;
      act_blk     <= '0;
      er_blk      <= '0;
      pend_blk    <= '0;
      cnt         <= '0;
    end else begin
      op_start   <= 1'b0;
      op_suspend <= 1'b0;
      op_resume  <= 1'b0;
      if (launch) begin
        op_start <= 1'b1;
        op_kind  <= l_kind;
        op_block <= l_blk;
        act_kind <= l_kind;
        act_blk  <= l_blk;
        if (l_kind == K_ERASE) er_blk <= l_blk;
        ready    <= 1'b0;
        state    <= S_BUSY;
      end else if (set_seq || set_pgm) begin
        state <= S_IDLE;
      end else begin
        case (state)
          S_BUSY: begin
            if (op_done) begin
              ready <= 1'b1;
              state <= S_IDLE;
            end else if (wr_en) begin
              if (cmd.rd_array)  mode_status <= 1'b0;
              if (cmd.rd_status) mode_status <= 1'b1;
              if (cmd.suspend && !esusp) begin
                op_suspend <= 1'b1;
                ready      <= 1'b1;
                state      <= S_IDLE;
                if (act_kind == K_ERASE) esusp <= 1'b1;
                else                     psusp <= 1'b1;
              end
            end
          end
          S_IDLE: begin
            if (wr_en) begin
              if (cmd.rd_array)  mode_status <= 1'b0;
              if (cmd.rd_status) mode_status <= 1'b1;
              if (cmd.word && !err_any && !psusp) begin
                mode_status <= 1'b1;
                state       <= S_WP_DATA;
              end
              if (cmd.buf_pgm && !err_any && !psusp) begin
                mode_status <= 1'b1;
                pend_blk    <= wr_blk;
                state       <= S_BP_COUNT;
              end
              if (cmd.erase && !err_any && !psusp && !esusp) begin
                mode_status <= 1'b1;
                pend_blk    <= wr_blk;
                state       <= S_ER_CONF;
              end
              if (cmd.confirm && (psusp || esusp)) begin
                op_resume <= 1'b1;
                ready     <= 1'b0;
                state     <= S_BUSY;
                if (psusp) begin
                  psusp    <= 1'b0;
                  op_kind  <= act_kind;
                  op_block <= act_blk;
                end else begin
                  esusp    <= 1'b0;
                  op_kind  <= K_ERASE;
                  op_block <= er_blk;
                  act_kind <= K_ERASE;
                  act_blk  <= er_blk;
                end
              end
            end
          end
          S_BP_COUNT: if (wr_en) begin
            cnt   <= wr_data[CNT_W-1:0];
            state <= S_BP_LOAD;
          end
          S_BP_LOAD: if (wr_en) begin
            if (cnt == '0) state <= S_BP_CONF;
            else           cnt   <= cnt - 1'b1;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import flc_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int BLK_W     = 4,
  parameter int BUF_WORDS = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              op_done,
  output logic              rd_sel,
  output logic [7:0]        status,
  output logic              op_start,
  output logic              op_suspend,
  output logic              op_resume,
  output logic [1:0]        op_kind,
  output logic [BLK_W-1:0]  op_block
);
  cmd_t             cmd;
  logic [BLK_W-1:0] wr_blk;
  logic ready, esusp, psusp, mode_status;
  logic set_seq, set_pgm, do_clear, err_erase, err_pgm;

  assign wr_blk = wr_addr[ADDR_W-1 -: BLK_W];

  flc_decode u_dec (.code(wr_data), .cmd(cmd));

  flc_seq #(.BLK_W(BLK_W), .BUF_WORDS(BUF_WORDS)) u_seq (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .wr_blk(wr_blk),
    .cmd(cmd), .op_done(op_done), .err_any(err_erase | err_pgm),
    .ready(ready), .esusp(esusp), .psusp(psusp), .mode_status(mode_status),
    .op_start(op_start), .op_suspend(op_suspend), .op_resume(op_resume),
    .op_kind(op_kind), .op_block(op_block),
    .set_seq(set_seq), .set_pgm(set_pgm), .do_clear(do_clear)
  );

  flc_errs u_err (
    .clk(clk), .rst(rst), .set_seq(set_seq), .set_pgm(set_pgm), .clr(do_clear),
    .err_erase(err_erase), .err_pgm(err_pgm)
  );

  assign rd_sel = ready ? mode_status : 1'b1;
  assign status = {ready, esusp, err_erase, err_pgm, 1'b0, psusp, 2'b00};
endmodule

// File: rtl/flc_sva.sv
module flc_sva (
  input logic       clk,
  input logic       rst,
  input logic       wr_en,
  input logic [7:0] wr_data,
  input logic       rd_sel,
  input logic [7:0] status,
  input logic       op_start,
  input logic       op_suspend,
  input logic       op_resume
);
  assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (status == 8'h80 && !op_start && !op_suspend && !op_resume));

  assert_start_busy_R3: assert property (@(posedge clk) disable iff (rst)
    op_start |-> !status[7]);

  assert_start_after_write_R3: assert property (@(posedge clk) disable iff (rst)
    op_start |-> $past(wr_en));

  assert_one_event_R3: assert property (@(posedge clk) disable iff (rst)
    $onehot0({op_start, op_suspend, op_resume}));

  assert_busy_reads_status_R4: assert property (@(posedge clk) disable iff (rst)
    !status[7] |-> rd_sel);

  assert_suspend_flags_R11: assert property (@(posedge clk) disable iff (rst)
    op_suspend |-> (status[7] && (status[6] != status[2])));

  assert_resume_busy_R12: assert property (@(posedge clk) disable iff (rst)
    op_resume |-> (!status[7] && !status[6] && !status[2]));

  assert_sticky_err_R14: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(status[4]) && !($past(wr_en) && $past(wr_data) == 8'h50))
      |-> status[4]);
endmodule

bind flash_cmd_decoder flc_sva u_flc_sva (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_sel(rd_sel),
  .status(status), .op_start(op_start), .op_suspend(op_suspend), .op_resume(op_resume)
);

// File: tb/sim_flash_cmd_decoder.sv
module sim_flash_cmd_decoder;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [7:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       op_done = 1'b0;
  logic       rd_sel, op_start, op_suspend, op_resume;
  logic [7:0] status;
  logic [1:0] op_kind;
  logic [3:0] op_block;
  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  flash_cmd_decoder #(.ADDR_W(8), .BLK_W(4), .BUF_WORDS(16)) u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .op_done(op_done), .rd_sel(rd_sel), .status(status), .op_start(op_start),
    .op_suspend(op_suspend), .op_resume(op_resume), .op_kind(op_kind), .op_block(op_block)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic done_pulse();
    @(negedge clk);
    op_done = 1'b1;
    @(negedge clk);
    op_done = 1'b0;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    summary();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 status", status, 8'h80);
    chk("R1 rd_sel", rd_sel, 0);
    chk("R1 pulses", {op_start, op_suspend, op_resume}, 0);

    // R2 read source selection
    wr(8'h00, 8'h70); chk("R2 status select", rd_sel, 1);
    wr(8'h00, 8'hFF); chk("R2 array select", rd_sel, 0);
    // R2 sweep of bytes with no effect in idle ready state (includes D0, B0 for R11)
    for (int c = 0; c < 256; c++) begin
      if (c == 8'h40 || c == 8'hE8 || c == 8'h20 || c == 8'h70 || c == 8'h50) continue;
      wr(8'(c), 8'(c));
      chk("R2 ignored status", status, 8'h80);
      chk("R2 ignored rd_sel", rd_sel, 0);
      chk("R2 R11 ignored pulses", {op_start, op_suspend, op_resume}, 0);
    end

    // R3 word program per block, R4 busy forces status read
    for (int b = 0; b < 16; b++) begin
      wr(8'(b << 4), 8'h40);
      chk("R3 setup rd_sel", rd_sel, 1);
      chk("R3 setup no start", op_start, 0);
      wr(8'((b << 4) | 3), 8'h5A);
      chk("R3 start", op_start, 1);
      chk("R3 kind", op_kind, 1);
      chk("R3 block", op_block, b);
      chk("R3 busy status", status, 8'h00);
      wr(8'h00, 8'hFF);
      chk("R4 busy rd_sel", rd_sel, 1);
      chk("R3 single pulse", op_start, 0);
      done_pulse();
      chk("R3 ready", status, 8'h80);
      chk("R4 array after done", rd_sel, 0);
    end

    // R5 erase per block
    for (int b = 0; b < 16; b++) begin
      wr(8'(b << 4), 8'h20);
      wr(8'((b << 4) | 1), 8'hD0);
      chk("R5 start", op_start, 1);
      chk("R5 kind", op_kind, 3);
      chk("R5 block", op_block, b);
      chk("R5 busy", status, 8'h00);
      done_pulse();
      chk("R5 ready", status, 8'h80);
    end

    // R6 bad erase confirms, R9 clear
    wr(8'h30, 8'h20); wr(8'h40, 8'hD0);
    chk("R6 wrong block no start", op_start, 0);
    chk("R6 wrong block status", status, 8'hB0);
    wr(8'h00, 8'h50); chk("R9 clear", status, 8'h80);
    wr(8'h30, 8'h20); wr(8'h30, 8'h12);
    chk("R6 wrong byte no start", op_start, 0);
    chk("R6 wrong byte status", status, 8'hB0);
    wr(8'h00, 8'h50); chk("R9 clear again", status, 8'h80);

    // R7 buffered program over every legal count
    for (int n = 0; n < 16; n++) begin
      wr(8'h50, 8'hE8);
      wr(8'h50, 8'(n));
      for (int i = 0; i <= n; i++) begin
        wr(8'(8'h50 + i), 8'hD0);
        chk("R7 load no start", op_start, 0);
      end
      wr(8'h5F, 8'hD0);
      chk("R7 start", op_start, 1);
      chk("R7 kind", op_kind, 2);
      chk("R7 block", op_block, 5);
      chk("R7 busy", status, 8'h00);
      done_pulse();
    end
    wr(8'h50, 8'hE8); wr(8'h50, 8'd16);
    chk("R7 count too large", status, 8'hB0);
    wr(8'h00, 8'h50);
    wr(8'h50, 8'hE8); wr(8'h50, 8'hFF);
    chk("R7 count 255", status, 8'hB0);
    wr(8'h00, 8'h50);

    // R8 bad buffered confirm
    wr(8'h50, 8'hE8); wr(8'h50, 8'h00); wr(8'h50, 8'h11); wr(8'h50, 8'h40);
    chk("R8 wrong byte no start", op_start, 0);
    chk("R8 wrong byte status", status, 8'hB0);
    wr(8'h00, 8'h50);
    wr(8'h50, 8'hE8); wr(8'h50, 8'h00); wr(8'h50, 8'h11); wr(8'h60, 8'hD0);
    chk("R8 wrong block status", status, 8'hB0);

    // R10 gating and R14 stickiness (error still set)
    wr(8'h20, 8'h40); wr(8'h20, 8'h33);
    chk("R10 word rejected", op_start, 0);
    wr(8'h20, 8'hE8); wr(8'h20, 8'h00);
    chk("R10 buffer rejected", op_start, 0);
    wr(8'h20, 8'h20); wr(8'h20, 8'hD0);
    chk("R10 erase rejected", op_start, 0);
    chk("R10 R14 status held", status, 8'hB0);
    wr(8'h00, 8'h70); wr(8'h00, 8'hFF); wr(8'h00, 8'hB0);
    chk("R14 sticky", status, 8'hB0);
    wr(8'h00, 8'h50); chk("R14 cleared", status, 8'h80);

    // R11 program suspend, R12 resume
    wr(8'h20, 8'h40); wr(8'h21, 8'h77);
    chk("R11 program started", op_start, 1);
    wr(8'hF7, 8'hB0);
    chk("R11 suspend pulse", op_suspend, 1);
    chk("R11 program suspend status", status, 8'h84);
    wr(8'h00, 8'hD0);
    chk("R12 resume pulse", op_resume, 1);
    chk("R12 resume kind", op_kind, 1);
    chk("R12 resume block", op_block, 2);
    chk("R12 resume status", status, 8'h00);
    done_pulse();
    chk("R12 done", status, 8'h80);

    // R11 erase suspend and R13 nested operations
    wr(8'h30, 8'h20); wr(8'h30, 8'hD0);
    wr(8'h9A, 8'hB0);
    chk("R11 erase suspend pulse", op_suspend, 1);
    chk("R11 erase suspend status", status, 8'hC0);
    wr(8'h60, 8'h40); wr(8'h61, 8'h01);
    chk("R13 nested start", op_start, 1);
    chk("R13 nested block", op_block, 6);
    chk("R13 nested busy", status, 8'h40);
    wr(8'h00, 8'hB0);
    chk("R13 nested suspend ignored", op_suspend, 0);
    chk("R13 nested status", status, 8'h40);
    done_pulse();
    chk("R13 back to erase suspend", status, 8'hC0);
    wr(8'h30, 8'h40); wr(8'h35, 8'h01);
    chk("R13 same block no start", op_start, 0);
    chk("R13 same block status", status, 8'hD0);
    wr(8'h00, 8'h50); chk("R13 R9 clear keeps suspend", status, 8'hC0);
    wr(8'h30, 8'hE8); wr(8'h30, 8'h00); wr(8'h30, 8'h01); wr(8'h30, 8'hD0);
    chk("R13 buffer same block no start", op_start, 0);
    chk("R13 buffer same block status", status, 8'hD0);
    wr(8'h00, 8'h50);
    wr(8'h10, 8'h20); wr(8'h10, 8'hD0);
    chk("R12 erase resume pulse", op_resume, 1);
    chk("R12 erase resume kind", op_kind, 3);
    chk("R12 erase resume block", op_block, 3);
    chk("R12 erase resume status", status, 8'h00);
    done_pulse();
    chk("R12 erase done", status, 8'h80);

    summary();
  end
endmodule